// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns one pair of parallel audio samples into a bit stream on a three-wire serial link. The link has a bit clock, a frame clock and a data line. Four framings are available: left-justified, I2S, right-justified and a time-division multiplexed (TDM) frame that holds several stereo pairs. The word length per channel is chosen from 16, 18, 20 or 24 bits. Each channel owns a 32-slot half of a 64-slot pair, and every slot that carries no sample bit is driven low.

In master mode the block divides its system clock to make the bit clock, and it generates the frame clock itself. In slave mode it follows a bit clock and a frame clock from outside. Both are brought into the system clock domain through two-stage synchronizers. The samples and the format and length selects are captured at each frame start, so a change in the middle of a frame only takes effect in the next frame.

Top module: `audio_serial_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sdata_out`, `fclk_out` and `bclk_out` are 0.
- R2: In master mode `bclk_out` starts low after reset and toggles every `BCLK_DIV` system clocks. A non-TDM frame lasts 64 bit-clock periods. `fclk_out` is high through slots 0..31 for left-justified and right-justified, and high through slots 32..63 for I2S.
- R3: In master mode `sdata_out` and `fclk_out` change only on the system clock cycle in which `bclk_out` falls, so they are stable across each rising bit-clock edge.
- R4: Left-justified (`fmt_sel`=0): the left word's MSB is in slot 0 and the right word's MSB is in slot 32. Bits follow MSB first, one per slot.
- R5: I2S (`fmt_sel`=1): each MSB lies one slot after its half-frame boundary, in slots 1 and 33.
- R6: Right-justified (`fmt_sel`=2): each LSB lies in the last slot of its half, slots 31 and 63. The MSB therefore sits at slot 32−W of that half.
- R7: `wlen_sel` codes 0, 1, 2 and 3 give W = 16, 18, 20 and 24. A sample is taken from bits W−1..0 of its 24-bit input, and the bits above W−1 have no effect on the output.
- R8: TDM (`fmt_sel`=3): the frame lasts 64×N slots, with N = `MASTER_PAIRS` in master mode. `fclk_out` is high during slot 0 only. The block's pair is placed left-justified in slots 0..63.
- R9: Every slot outside a sample word is 0, including all TDM slots from 64 upward.
- R10: The samples, format and word length are captured at each frame start. Changes to these inputs during a frame leave the bits of that frame unchanged.
- R11: In slave mode `bclk_out` and `fclk_out` stay 0 and a falling edge on `bclk_in` advances one slot. A frame-clock edge that enters the left half restarts the frame at slot 0, and one that enters the right half moves to slot 32. In TDM only a rising edge counts, and it restarts the frame. Each slot's bit is valid before the following rising edge of `bclk_in`, when that edge comes at least 4 system clocks after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1: generate the bit and frame clocks; 0: follow the external clocks |
| fmt_sel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 TDM |
| wlen_sel | input | 2 | Word length code: 0=16, 1=18, 2=20, 3=24 bits |
| left_word | input | 24 | Left sample, LSB-aligned |
| right_word | input | 24 | Right sample, LSB-aligned |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| fclk_out | output | 1 | Generated frame clock (master mode) |
| sdata_out | output | 1 | Serial data line |

## Verification
The bench uses `BCLK_DIV`=2, `MASTER_PAIRS`=4 and `MAX_PAIRS`=8. A bit period is then four system clocks, a standard frame is 256 clocks and a master TDM frame is 1024 clocks. This lets all sixteen combinations of format and word length run in master mode, with mid-frame changes to samples and selects, well inside the cycle budget. In slave mode the bench drives a 128-slot TDM frame (two pairs). This shows that the frame length follows the external frame pulse rather than a fixed count, and it exercises the all-zero tail beyond slot 63.

// File: rtl/astx_pkg.sv
package astx_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int SUB_BITS  = 32;
    localparam int PAIR_BITS = 2 * SUB_BITS;

    typedef enum logic [1:0] {
        FMT_LEFT  = 2'd0,
        FMT_I2S   = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_TDM   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_18 = 2'd1,
        WL_20 = 2'd2,
        WL_24 = 2'd3
    } wlen_e;

    typedef struct packed {
        fmt_e  fmt;
        wlen_e wl;
    } cfg_t;

    // number of sample bits for a length code
    function automatic logic [5:0] wlen_bits(wlen_e w);
        case (w)
            WL_16:   return 6'd16;
            WL_18:   return 6'd18;
            WL_20:   return 6'd20;
            default: return 6'd24;
        endcase
    endfunction

    // slot within a half-frame where the MSB lands
    function automatic logic [5:0] lead_offset(fmt_e f, wlen_e w);
        case (f)
            FMT_I2S:   return 6'd1;
            FMT_RIGHT: return 6'(SUB_BITS) - wlen_bits(w);
            default:   return 6'd0;
        endcase
    endfunction

    // frame clock level that marks the left half
    function automatic logic left_level(fmt_e f);
        return (f != FMT_I2S);
    endfunction

endpackage

// File: rtl/astx_bclk_gen.sv
module astx_bclk_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic bclk,
    output logic fall_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(DIV - 1));
    assign fall_tick = en & wrap & bclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_hold_chk
            // R2: a bit-clock level lasts more than one system clock
            a_r2_bclk_min_half: assert property (@(posedge clk) disable iff (rst)
                en && $past(en) && !$stable(bclk) |=> $stable(bclk));
        end
    endgenerate

endmodule

// File: rtl/astx_slave_in.sv
module astx_slave_in (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bclk_ext,
    input  logic fclk_ext,
    output logic fall_tick,
    output logic fclk_lvl,
    output logic fclk_edge
);
    logic [1:0] bclk_sync;
    logic [1:0] fclk_sync;
    logic       bclk_dly;
    logic       fclk_dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_sync <= '0;
            fclk_sync <= '0;
            bclk_dly  <= 1'b0;
            fclk_dly  <= 1'b0;
        end else begin
            bclk_sync <= {bclk_sync[0], bclk_ext};
            fclk_sync <= {fclk_sync[0], fclk_ext};
            bclk_dly  <= bclk_sync[1];
            fclk_dly  <= fclk_sync[1];
        end
    end

    assign fall_tick = en & bclk_dly & ~bclk_sync[1];
    assign fclk_lvl  = fclk_sync[1];
    assign fclk_edge = fclk_sync[1] ^ fclk_dly;

    // R11: one external falling edge yields exactly one slot advance
    a_r11_single_tick: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !fall_tick);

endmodule

// File: rtl/astx_slot_ctrl.sv
module astx_slot_ctrl
    import astx_pkg::*;
#(
    parameter int SLOT_W       = 9,
    parameter int MASTER_PAIRS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              tick,
    input  logic              fclk_lvl,
    input  logic              fclk_edge,
    input  fmt_e              fmt_in,
    input  wlen_e             wlen_in,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              frame_start,
    output cfg_t              cfg,
    output cfg_t              cfg_nxt,
    output logic              fclk
);
    localparam logic [SLOT_W-1:0] SLOT_IDLE = '1;
    localparam logic [SLOT_W-1:0] HALF      = SLOT_W'(SUB_BITS);
    localparam logic [SLOT_W-1:0] LAST_STD  = SLOT_W'(PAIR_BITS - 1);
    localparam logic [SLOT_W-1:0] LAST_TDM  = SLOT_W'(PAIR_BITS * MASTER_PAIRS - 1);

    logic              wrap;
    logic [SLOT_W-1:0] last_slot;

    function automatic logic frame_level(fmt_e f, logic [SLOT_W-1:0] s);
        case (f)
            FMT_TDM: return (s == '0);
            FMT_I2S: return (s >= HALF);
            default: return (s < HALF);
        endcase
    endfunction

    assign last_slot = (cfg.fmt == FMT_TDM) ? LAST_TDM : LAST_STD;

    always_comb begin
        wrap     = 1'b0;
        slot_nxt = slot;
        if (master_en) begin
            if (slot >= last_slot) begin
                slot_nxt = '0;
                wrap     = 1'b1;
            end else begin
                slot_nxt = slot + 1'b1;
            end
        end else if (fclk_edge && (fmt_in != FMT_TDM || fclk_lvl)) begin
            if (fmt_in == FMT_TDM || fclk_lvl == left_level(fmt_in)) begin
                slot_nxt = '0;
                wrap     = 1'b1;
            end else begin
                slot_nxt = HALF;
            end
        end else if (slot != SLOT_IDLE) begin
            slot_nxt = slot + 1'b1;
        end
    end

    assign frame_start = tick & wrap;
    assign cfg_nxt     = frame_start ? '{fmt: fmt_in, wl: wlen_in} : cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOT_IDLE;
            cfg  <= '{fmt: FMT_LEFT, wl: WL_16};
            fclk <= 1'b0;
        end else begin
            if (!master_en) begin
                fclk <= 1'b0;
            end else if (tick) begin
                fclk <= frame_level(cfg_nxt.fmt, slot_nxt);
            end
            if (tick) begin
                slot <= slot_nxt;
                cfg  <= cfg_nxt;
            end
        end
    end

    // R10: selects captured only at a frame start
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cfg));

    // R11: an external half-frame edge lands on slot 0 or slot 32
    a_r11_half_align: assert property (@(posedge clk) disable iff (rst)
        !master_en && tick && fclk_edge && fmt_in != FMT_TDM |=> (slot == '0 || slot == HALF));

endmodule

// File: rtl/astx_bit_sel.sv
module astx_bit_sel
    import astx_pkg::*;
#(
    parameter int SLOT_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                frame_start,
    input  cfg_t                cfg_nxt,
    input  logic [SLOT_W-1:0]   slot_nxt,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                sdata
);
    logic [SAMPLE_W-1:0] lat_l;
    logic [SAMPLE_W-1:0] lat_r;
    logic [SAMPLE_W-1:0] eff_l;
    logic [SAMPLE_W-1:0] eff_r;
    logic [31:0]         word;
    logic [6:0]          pos;
    logic [6:0]          off;
    logic [6:0]          nbits;
    logic [6:0]          rel;
    logic [6:0]          bidx_full;
    logic [4:0]          bidx;
    logic                hit;
    logic                bit_nxt;

    assign eff_l = frame_start ? left_in  : lat_l;
    assign eff_r = frame_start ? right_in : lat_r;

    always_comb begin
        pos       = {2'b00, slot_nxt[4:0]};
        off       = {1'b0, lead_offset(cfg_nxt.fmt, cfg_nxt.wl)};
        nbits     = {1'b0, wlen_bits(cfg_nxt.wl)};
        rel       = pos - off;
        bidx_full = nbits - 7'd1 - rel;
        bidx      = bidx_full[4:0];
        word      = slot_nxt[5] ? {8'b0, eff_r} : {8'b0, eff_l};
        hit       = (slot_nxt < SLOT_W'(PAIR_BITS)) && (pos >= off) && (pos < off + nbits);
        bit_nxt   = hit & word[bidx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_l <= '0;
            lat_r <= '0;
            sdata <= 1'b0;
        end else if (tick) begin
            if (frame_start) begin
                lat_l <= left_in;
                lat_r <= right_in;
            end
            sdata <= bit_nxt;
        end
    end

    // R10: captured samples hold between frame starts
    a_r10_sample_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(lat_l) && $stable(lat_r));

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import astx_pkg::*;
#(
    parameter int BCLK_DIV     = 2,
    parameter int MASTER_PAIRS = 4,
    parameter int MAX_PAIRS    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                master_en,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    input  logic                bclk_in,
    input  logic                fclk_in,
    output logic                bclk_out,
    output logic                fclk_out,
    output logic                sdata_out
);
    localparam int PAIRS_TOP = (MAX_PAIRS > MASTER_PAIRS) ? MAX_PAIRS : MASTER_PAIRS;
    localparam int SLOT_W    = $clog2(PAIR_BITS * PAIRS_TOP);

    logic              m_tick;
    logic              s_tick;
    logic              tick;
    logic              fclk_lvl;
    logic              fclk_edge;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] slot_nxt;
    logic              frame_start;
    cfg_t              cfg;
    cfg_t              cfg_nxt;

    astx_bclk_gen #(.DIV(BCLK_DIV)) u_bclk (
        .clk       (clk),
        .rst       (rst),
        .en        (master_en),
        .bclk      (bclk_out),
        .fall_tick (m_tick)
    );

    astx_slave_in u_slave (
        .clk       (clk),
        .rst       (rst),
        .en        (!master_en),
        .bclk_ext  (bclk_in),
        .fclk_ext  (fclk_in),
        .fall_tick (s_tick),
        .fclk_lvl  (fclk_lvl),
        .fclk_edge (fclk_edge)
    );

    assign tick = master_en ? m_tick : s_tick;

    astx_slot_ctrl #(.SLOT_W(SLOT_W), .MASTER_PAIRS(MASTER_PAIRS)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .master_en   (master_en),
        .tick        (tick),
        .fclk_lvl    (fclk_lvl),
        .fclk_edge   (fclk_edge),
        .fmt_in      (fmt_e'(fmt_sel)),
        .wlen_in     (wlen_e'(wlen_sel)),
        .slot        (slot),
        .slot_nxt    (slot_nxt),
        .frame_start (frame_start),
        .cfg         (cfg),
        .cfg_nxt     (cfg_nxt),
        .fclk        (fclk_out)
    );

    astx_bit_sel #(.SLOT_W(SLOT_W)) u_bits (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .frame_start (frame_start),
        .cfg_nxt     (cfg_nxt),
        .slot_nxt    (slot_nxt),
        .left_in     (left_word),
        .right_in    (right_word),
        .sdata       (sdata_out)
    );

    // R3: master data moves only with a falling bit clock
    a_r3_data_on_fall: assert property (@(posedge clk) disable iff (rst)
        master_en && $past(master_en) && !$stable(sdata_out) |-> $fell(bclk_out));

    // R8: master TDM frame pulse only in slot 0
    a_r8_tdm_pulse: assert property (@(posedge clk) disable iff (rst)
        master_en && fclk_out && cfg.fmt == FMT_TDM |-> slot == '0);

    // R9: nothing beyond the block's own pair
    a_r9_tail_zero: assert property (@(posedge clk) disable iff (rst)
        slot >= SLOT_W'(PAIR_BITS) |-> !sdata_out);

    // R11: clock outputs quiet in slave mode
    a_r11_slave_quiet: assert property (@(posedge clk) disable iff (rst)
        !master_en && !$past(master_en) |-> !bclk_out && !fclk_out);

endmodule

// File: tb/audio_serial_tx_tb_top.sv
`timescale 1ns/1ps
module audio_serial_tx_tb_top;

    localparam int DIV    = 2;
    localparam int MPAIRS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_en = 1'b1;
    logic [1:0]  fmt_sel = 2'd0;
    logic [1:0]  wlen_sel = 2'd0;
    logic [23:0] left_word = '0;
    logic [23:0] right_word = '0;
    logic        bclk_in = 1'b1;
    logic        fclk_in = 1'b0;
    logic        bclk_out;
    logic        fclk_out;
    logic        sdata_out;

    int checks = 0;
    int fails  = 0;
    bit master_run = 1'b1;
    bit slave_run  = 1'b0;
    bit finished   = 1'b0;

    always #2 clk = ~clk;

    audio_serial_tx #(.BCLK_DIV(DIV), .MASTER_PAIRS(MPAIRS), .MAX_PAIRS(8)) dut_i (
        .clk(clk), .rst(rst), .master_en(master_en), .fmt_sel(fmt_sel),
        .wlen_sel(wlen_sel), .left_word(left_word), .right_word(right_word),
        .bclk_in(bclk_in), .fclk_in(fclk_in), .bclk_out(bclk_out),
        .fclk_out(fclk_out), .sdata_out(sdata_out)
    );

    function automatic int wbits(int w);
        case (w)
            0: return 16;
            1: return 18;
            2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic exp_bit(int f, int w, logic [23:0] l, logic [23:0] r, int s);
        int nb = wbits(w);
        int off;
        int k;
        logic [23:0] wd;
        if (s < 0 || s >= 64) return 1'b0;
        wd  = (s >= 32) ? r : l;
        off = (f == 1) ? 1 : (f == 2) ? 32 - nb : 0;
        k   = (s % 32) - off;
        if (k < 0 || k >= nb) return 1'b0;
        return wd[nb - 1 - k];
    endfunction

    function automatic logic exp_fclk(int f, int s);
        if (s < 0) return 1'b0;
        if (f == 3) return s == 0;
        if (f == 1) return s >= 32;
        return s < 32;
    endfunction

    function automatic string data_tag(int f, int s);
        if (s >= 64) return "R8 R9";
        case (f)
            0: return "R4 R7 R9 R10";
            1: return "R5 R7 R9 R10";
            2: return "R6 R7 R9 R10";
            default: return "R8 R7 R9 R10";
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural master reference, evaluated away from the active edge
    int          n_edges;
    int          m_slot;
    int          m_fmt;
    int          m_wl;
    logic [23:0] m_l;
    logic [23:0] m_r;
    logic        m_bclk;
    logic        m_sd;
    logic        m_fc;
    logic        prev_sd;
    logic        prev_bclk;

    always @(negedge clk) begin
        if (master_run) begin
            if (rst) begin
                n_edges = 0; m_slot = -1; m_fmt = 0; m_wl = 0;
                m_l = '0; m_r = '0; m_bclk = 1'b0; m_sd = 1'b0; m_fc = 1'b0;
                chk("R1 sdata in reset", sdata_out, 1'b0);
                chk("R1 fclk in reset", fclk_out, 1'b0);
                chk("R1 bclk in reset", bclk_out, 1'b0);
            end else begin
                n_edges++;
                if (n_edges % DIV == 0) begin
                    m_bclk = ~m_bclk;
                    if (!m_bclk) begin
                        int last;
                        last = (m_fmt == 3) ? 64 * MPAIRS - 1 : 63;
                        if (m_slot < 0 || m_slot >= last) begin
                            m_slot = 0; m_fmt = fmt_sel; m_wl = wlen_sel;
                            m_l = left_word; m_r = right_word;
                        end else begin
                            m_slot++;
                        end
                        m_sd = exp_bit(m_fmt, m_wl, m_l, m_r, m_slot);
                        m_fc = exp_fclk(m_fmt, m_slot);
                    end
                end
                chk("R2 bclk_out", bclk_out, m_bclk);
                chk((m_fmt == 3) ? "R8 fclk_out" : "R2 fclk_out", fclk_out, m_fc);
                chk(data_tag(m_fmt, m_slot), sdata_out, m_sd);
                if (sdata_out !== prev_sd)
                    chk("R3 data change off falling edge", prev_bclk & ~bclk_out, 1'b1);
            end
            prev_sd   = sdata_out;
            prev_bclk = bclk_out;
        end
    end

    // slave-mode clock outputs must stay low
    always @(negedge clk) begin
        if (slave_run && !rst) begin
            chk("R11 bclk_out quiet", bclk_out, 1'b0);
            chk("R11 fclk_out quiet", fclk_out, 1'b0);
        end
    end

    task automatic drive_wait(int cycles);
        repeat (cycles) @(negedge clk);
        #1;
    endtask

    task automatic master_config(int f, int w, int frames);
        int span = ((f == 3) ? 64 * MPAIRS : 64) * 2 * DIV * frames + 90;
        fmt_sel = 2'(f);
        wlen_sel = 2'(w);
        for (int c = 0; c < span; c += 37) begin
            left_word  = 24'($urandom);
            right_word = 24'($urandom);
            drive_wait(37);
        end
    endtask

    task automatic slave_config(int f, int w, int pairs, int frames);
        int flen = (f == 3) ? 64 * pairs : 64;
        logic [23:0] sl;
        logic [23:0] sr;
        drive_wait(1);
        rst = 1'b1;
        fmt_sel = 2'(f);
        wlen_sel = 2'(w);
        bclk_in = 1'b1;
        fclk_in = (f == 1) ? 1'b1 : 1'b0;
        left_word = 24'($urandom);
        right_word = 24'($urandom);
        drive_wait(4);
        rst = 1'b0;
        drive_wait(6);
        sl = '0;
        sr = '0;
        for (int fr = 0; fr < frames; fr++) begin
            for (int s = 0; s < flen; s++) begin
                bclk_in = 1'b0;
                fclk_in = exp_fclk(f, s);
                if (s == 0) begin
                    sl = left_word;
                    sr = right_word;
                end
                drive_wait(4);
                chk({"R11 ", data_tag(f, s)}, sdata_out, exp_bit(f, w, sl, sr, s));
                bclk_in = 1'b1;
                if (s == 7 || s == 40) begin
                    left_word  = 24'($urandom);
                    right_word = 24'($urandom);
                end
                drive_wait(4);
            end
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        drive_wait(10);
        rst = 1'b0;
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 4; w++) begin
                master_config(f, w, (f == 3) ? 2 : 3);
            end
        end
        drive_wait(1);
        master_run = 1'b0;
        rst = 1'b1;
        master_en = 1'b0;
        drive_wait(4);
        slave_run = 1'b1;
        slave_config(0, 3, 1, 3);
        slave_config(1, 0, 1, 3);
        slave_config(2, 1, 1, 3);
        slave_config(2, 3, 1, 2);
        slave_config(3, 2, 2, 3);
        slave_run = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule